// File: doc/BRIEF.md
# Event Primitive Mailbox Register

This block is a single-slot mailbox. An internal link controller uses it to hand event primitives to host software one at a time. Each internal source raises a request that carries a 4-bit primitive code and a 2-bit parameter. The block stores one accepted primitive in an 8-bit host-visible register and marks it available. It keeps that primitive until the host acknowledges it by writing a one to the available flag.

A request that arrives while the slot is still occupied is turned away. The stored code and parameter stay as they are, and a sticky lost flag is raised. That flag clears only when the available flag is cleared or on bus reset. In the same cycle as its request, each requester learns whether its primitive was taken or refused. Discarding or retrying is therefore left to the requester. For example, a received management frame that meets an occupied slot is dropped by its source, and no counters are updated.

Parameter meaning depends on the code:
- For a watchdog expiry, 1 marks the transmit-clock watchdog and 2 the receive-clock watchdog. A second expiry right after the first is refused and shows up as the lost flag.
- For a received management frame, the values 0 to 3 give the frame type:
  - 0: short enquiry
  - 1: full-status enquiry
  - 2: status reply
  - 3: update status

Top module: `prim_mailbox`

## Requirements
- R1: After bus reset (rst_n low), host_rdata reads 0x00.
- R2: host_rdata shows the register directly, with no added delay: bits 3:0 hold the code, bits 5:4 the parameter, bit 6 the available flag and bit 7 the lost flag.
- R3: A request that is accepted while the slot is free loads its code and parameter and sets the available flag. All three changes appear on the clock edge that ends the request cycle.
- R4: A host write with bit 6 set clears the available flag at the next edge. A host write with bit 6 clear leaves the available flag unchanged.
- R5: If a request arrives while the available flag is set and the host is not clearing it in that cycle, the request is rejected. Code and parameter keep their values, and the lost flag is set at the next edge.
- R6: Clearing the available flag also clears the lost flag. Host writes to bit 7 and to bits 5:0 have no effect.
- R7: When several requests are valid in a cycle in which the slot can be taken, the lowest requester index is accepted and the rest are rejected. Each such rejection sets the lost flag.
- R8: In the request cycle itself, every valid requester sees exactly one of req_accept or req_reject. An idle requester sees neither.
- R9: If a host clear and a request fall in the same cycle, the clear is applied first. The request is accepted, and the available flag stays set with the new contents.
- R10: The lost flag stays set through further cycles and further rejections until the available flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous bus reset |
| req_valid | input | NUM_REQ | One request strobe per internal source |
| req_code | input | 4*NUM_REQ | Primitive code per source, source i in bits 4i+3:4i |
| req_parm | input | 2*NUM_REQ | Parameter per source, source i in bits 2i+1:2i |
| req_accept | output | NUM_REQ | Primitive from this source was stored |
| req_reject | output | NUM_REQ | Primitive from this source was refused |
| host_wr | input | 1 | Host write strobe to the register |
| host_wdata | input | 8 | Host write data (only bit 6 acts) |
| host_rdata | output | 8 | Register read-back |

## Verification
The bench targets these corner cases:
- **Post into an occupied slot.** A design that overwrote the slot would show the new code. A design that missed the lost flag would show bit 7 low.
- **Host clear in the same cycle as a post.** A design that judged the post against the old flag would reject it and lose the primitive.
- **Several sources at once.** A wrong priority stores the wrong code. Missing losers' feedback leaves req_reject low.
- **Writes to the read-only bits and zero-writes to the available flag.** These must leave the register untouched. A plain read-write register would change its fields or drop the lost flag.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int CODE_W = 4;
    localparam int PARM_W = 2;
    localparam int REG_W  = CODE_W + PARM_W + 2;

    // bit positions used by host software
    localparam int AVAIL_BIT = CODE_W + PARM_W;
    localparam int LOST_BIT  = CODE_W + PARM_W + 1;

    typedef struct packed {
        logic              lost;
        logic              avail;
        logic [PARM_W-1:0] parm;
        logic [CODE_W-1:0] code;
    } mbx_reg_t;

    localparam mbx_reg_t MBX_RESET = '{lost: 1'b0, avail: 1'b0, parm: '0, code: '0};

endpackage

// File: rtl/mbx_prio_pick.sv
module mbx_prio_pick #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] valid,
    output logic [NUM_REQ-1:0] grant,
    output logic [IDX_W-1:0]   grant_idx,
    output logic               any
);

    // blocked[i] is high when some lower index is valid
    logic [NUM_REQ:0] blocked;

    assign blocked[0] = 1'b0;

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_chain
        assign grant[g]     = valid[g] & ~blocked[g];
        assign blocked[g+1] = blocked[g] | valid[g];
    end

    assign any = blocked[NUM_REQ];

    always_comb begin
        grant_idx = '0;
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (valid[i]) begin
                grant_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mbx_req_mux.sv
module mbx_req_mux
    import mbx_pkg::*;
#(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ*CODE_W-1:0] req_code,
    input  logic [NUM_REQ*PARM_W-1:0] req_parm,
    input  logic [IDX_W-1:0]          sel,
    output logic [CODE_W-1:0]         code,
    output logic [PARM_W-1:0]         parm
);

    always_comb begin
        code = '0;
        parm = '0;
        for (int i = 0; i < NUM_REQ; i++) begin
            if (sel == IDX_W'(i)) begin
                code = req_code[i*CODE_W +: CODE_W];
                parm = req_parm[i*PARM_W +: PARM_W];
            end
        end
    end

endmodule

// File: rtl/mbx_host_decode.sv
module mbx_host_decode
    import mbx_pkg::*;
(
    input  logic             host_wr,
    input  logic [REG_W-1:0] host_wdata,
    output logic             clr_avail
);

    // only the available flag is writable (write one to clear)
    logic unused_wbits;

    assign clr_avail    = host_wr & host_wdata[AVAIL_BIT];
    assign unused_wbits = ^{host_wdata[LOST_BIT], host_wdata[AVAIL_BIT-1:0]};

endmodule

// File: rtl/prim_mailbox.sv
module prim_mailbox
    import mbx_pkg::*;
#(
    parameter int NUM_REQ = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REQ-1:0]        req_valid,
    input  logic [NUM_REQ*CODE_W-1:0] req_code,
    input  logic [NUM_REQ*PARM_W-1:0] req_parm,
    output logic [NUM_REQ-1:0]        req_accept,
    output logic [NUM_REQ-1:0]        req_reject,
    input  logic                      host_wr,
    input  logic [REG_W-1:0]          host_wdata,
    output logic [REG_W-1:0]          host_rdata
);

    localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

    typedef struct packed {
        mbx_reg_t               mbx;
        logic [NUM_REQ-1:0]     acc;
        logic [NUM_REQ-1:0]     rej;
    } mbx_next_t;

    mbx_reg_t  reg_q;
    mbx_next_t nxt_d;

    logic               clr_avail;
    logic [NUM_REQ-1:0] pick_grant;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_any;
    logic [CODE_W-1:0]  sel_code;
    logic [PARM_W-1:0]  sel_parm;

    mbx_host_decode u_dec (
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .clr_avail  (clr_avail)
    );

    mbx_prio_pick #(.NUM_REQ(NUM_REQ)) u_pick (
        .valid     (req_valid),
        .grant     (pick_grant),
        .grant_idx (pick_idx),
        .any       (pick_any)
    );

    mbx_req_mux #(.NUM_REQ(NUM_REQ)) u_mux (
        .req_code (req_code),
        .req_parm (req_parm),
        .sel      (pick_idx),
        .code     (sel_code),
        .parm     (sel_parm)
    );

    always_comb begin
        logic slot_free;
        nxt_d     = '{mbx: reg_q, acc: '0, rej: '0};
        slot_free = ~reg_q.avail | clr_avail;

        if (slot_free && pick_any) begin
            nxt_d.acc = pick_grant;
        end
        nxt_d.rej = req_valid & ~nxt_d.acc;

        if (clr_avail) begin
            nxt_d.mbx.avail = 1'b0;
            nxt_d.mbx.lost  = 1'b0;
        end
        if (|nxt_d.acc) begin
            nxt_d.mbx.code  = sel_code;
            nxt_d.mbx.parm  = sel_parm;
            nxt_d.mbx.avail = 1'b1;
        end
        if (|nxt_d.rej) begin
            nxt_d.mbx.lost = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= MBX_RESET;
        end else begin
            reg_q <= nxt_d.mbx;
        end
    end

    assign req_accept = nxt_d.acc;
    assign req_reject = nxt_d.rej;
    assign host_rdata = reg_q;

endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter int NUM_REQ = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] req_valid,
    input logic [NUM_REQ-1:0] req_accept,
    input logic [NUM_REQ-1:0] req_reject,
    input logic               host_wr,
    input logic [7:0]         host_wdata,
    input logic [7:0]         host_rdata
);

    logic host_clr;
    assign host_clr = host_wr & host_wdata[6];

    // R8
    feedback_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_accept | req_reject) == req_valid) && ((req_accept & req_reject) == '0));

    // R7
    single_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_accept));

    // R3
    accept_sets_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_accept) |=> host_rdata[6]);

    // R5
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[6] && !host_clr) |-> (req_accept == '0));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[6] && !host_clr) |=> (host_rdata[6] && $stable(host_rdata[5:0])));

    // R5
    reject_marks_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_reject) |=> host_rdata[7]);

    // R10
    lost_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[7] && !host_clr) |=> host_rdata[7]);

    // R6
    clear_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clr && (req_valid == '0)) |=> (host_rdata[7:6] == 2'b00));

endmodule

bind prim_mailbox mbx_chk #(.NUM_REQ(NUM_REQ)) u_mbx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .req_reject (req_reject),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
);

// File: tb/prim_mailbox_test.sv
`timescale 1ns/1ps
module prim_mailbox_test;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_valid = '0;
    logic [4*N-1:0] req_code = '0;
    logic [2*N-1:0] req_parm = '0;
    logic [N-1:0] req_accept, req_reject;
    logic         host_wr = 1'b0;
    logic [7:0]   host_wdata = '0;
    logic [7:0]   host_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    prim_mailbox #(.NUM_REQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .req_parm(req_parm), .req_accept(req_accept), .req_reject(req_reject),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    typedef struct packed {
        logic [3:0]  v;
        logic [15:0] code;
        logic [7:0]  parm;
        logic        wr;
        logic [7:0]  wd;
        logic [3:0]  acc;
        logic [3:0]  rej;
        logic [7:0]  rd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam logic [56:0] VEC [0:NV-1] = '{
        // R3 free slot, req0 code 5 parm 1
        {4'b0001, 16'h0005, 8'h01, 1'b0, 8'h00, 4'b0001, 4'b0000, 8'h55, 4'd3},
        // R5 occupied, req1 refused, fields kept, lost set
        {4'b0010, 16'h0070, 8'h08, 1'b0, 8'h00, 4'b0000, 4'b0010, 8'hD5, 4'd5},
        // R10 idle cycle, lost stays
        {4'b0000, 16'h0000, 8'h00, 1'b0, 8'h00, 4'b0000, 4'b0000, 8'hD5, 4'd10},
        // R6 write to bit 7 and bits 5:0 ignored
        {4'b0000, 16'h0000, 8'h00, 1'b1, 8'hBF, 4'b0000, 4'b0000, 8'hD5, 4'd6},
        // R4 write one to bit 6 clears avail (and lost)
        {4'b0000, 16'h0000, 8'h00, 1'b1, 8'h40, 4'b0000, 4'b0000, 8'h15, 4'd4},
        // R4 write while clear: no change
        {4'b0000, 16'h0000, 8'h00, 1'b1, 8'hFF, 4'b0000, 4'b0000, 8'h15, 4'd4},
        // R7 reqs 1,2,3: req1 wins code 3 parm 3
        {4'b1110, 16'hC930, 8'h9C, 1'b0, 8'h00, 4'b0010, 4'b1100, 8'hF3, 4'd7},
        // R9 clear with post from req3 code A parm 2
        {4'b1000, 16'hA000, 8'h80, 1'b1, 8'h40, 4'b1000, 4'b0000, 8'h6A, 4'd9},
        // R5 post while busy
        {4'b0001, 16'h000F, 8'h03, 1'b0, 8'h00, 4'b0000, 4'b0001, 8'hEA, 4'd5},
        // R6 clearing avail drops lost
        {4'b0000, 16'h0000, 8'h00, 1'b1, 8'h40, 4'b0000, 4'b0000, 8'h2A, 4'd6},
        // R3 req2 code 6 parm 0
        {4'b0100, 16'h0600, 8'h00, 1'b0, 8'h00, 4'b0100, 4'b0000, 8'h46, 4'd3},
        // R9 clear plus two posts: req0 wins, req1 lost
        {4'b0011, 16'h0021, 8'h07, 1'b1, 8'h40, 4'b0001, 4'b0010, 8'hF1, 4'd9},
        // R4 write 0xC0 clears, fields kept
        {4'b0000, 16'h0000, 8'h00, 1'b1, 8'hC0, 4'b0000, 4'b0000, 8'h31, 4'd4}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] v, input logic [15:0] c, input logic [7:0] p,
                         input logic w, input logic [7:0] d);
        req_valid  = v;
        req_code   = c;
        req_parm   = p;
        host_wr    = w;
        host_wdata = d;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset value
        check(host_rdata == 8'h00, "R1", "reset rdata", {8'h0, host_rdata}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t t;
            t = vec_t'(VEC[i]);
            drive(t.v, t.code, t.parm, t.wr, t.wd);
            #0.5;
            // R8 same-cycle feedback
            check({req_accept, req_reject} == {t.acc, t.rej}, $sformatf("R%0d/R8", t.req),
                  $sformatf("vec %0d acc/rej", i), {8'h0, req_accept, req_reject},
                  {8'h0, t.acc, t.rej});
            @(posedge clk);
            #0.5;
            check(host_rdata == t.rd, $sformatf("R%0d", t.req), $sformatf("vec %0d rdata", i),
                  {8'h0, host_rdata}, {8'h0, t.rd});
            @(negedge clk);
        end
        drive('0, '0, '0, 1'b0, 8'h00);
        @(negedge clk);

        // R2 field placement: clear then post code 9 parm 2 from req1
        drive(4'b0000, 16'h0, 8'h0, 1'b1, 8'h40);
        @(negedge clk);
        drive(4'b0010, 16'h0090, 8'h08, 1'b0, 8'h00);
        @(negedge clk);
        drive('0, '0, '0, 1'b0, 8'h00);
        check(host_rdata[3:0] == 4'h9, "R2", "code field", {12'h0, host_rdata[3:0]}, 16'h9);
        check(host_rdata[5:4] == 2'd2, "R2", "parm field", {14'h0, host_rdata[5:4]}, 16'h2);
        check(host_rdata[7:6] == 2'b01, "R2", "flag bits", {14'h0, host_rdata[7:6]}, 16'h1);

        // R10 repeated rejections keep lost set
        drive(4'b0001, 16'h0003, 8'h00, 1'b0, 8'h00);
        @(negedge clk);
        drive(4'b0100, 16'h0400, 8'h00, 1'b0, 8'h00);
        @(negedge clk);
        drive('0, '0, '0, 1'b0, 8'h00);
        @(negedge clk);
        check(host_rdata == 8'hE9, "R10", "lost sticky", {8'h0, host_rdata}, 16'hE9);

        // R1 mid-run reset clears everything
        rst_n = 1'b0;
        #1;
        check(host_rdata == 8'h00, "R1", "reset mid-run", {8'h0, host_rdata}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_rdata == 8'h00, "R1", "after reset", {8'h0, host_rdata}, 16'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule